// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block walks a ring of transmit descriptors held in system memory and feeds each frame to a MAC transmit stub. Software first programs the address of a descriptor in the ring, sets the transmit-on bit and writes the start-demand register. The engine then reads the current four-word descriptor over a word-wide request/acknowledge memory port. Each descriptor holds an options word, a buffer pointer, a status word carrying the frame length, and a next pointer.

If the MAC owns the descriptor, the engine passes the buffer pointer, length and pad/CRC flags to the MAC stub. It waits for the stub's completion and writes the outcome into the status word. It then clears the owner bit in the options word and moves to the next descriptor. If the CPU owns the descriptor, the engine stops and flags the descriptor as unavailable. It stays stopped until software writes the start-demand register again.

Interrupt status bits are held in the upper half of a 32-bit status register. Software clears a bit by writing 1 to it. Each bit has an enable at the same position, and the interrupt output is the OR of all enabled bits.

Top module: `tx_desc_ring`

## Requirements
- R1: A descriptor is fetched as four word reads at offsets 0, 4, 8 and 12 from the current pointer, in that order. The low four address bits of a programmed start address and of every next pointer are forced to zero.
- R2: When options bit 31 is 1 (MAC owns), the engine raises `mac_req` with `mac_buf` set to the buffer word and `mac_len` set to status bits [15:0]. `mac_pad` takes options bit 0 and `mac_crc` takes options bit 1. These are held until `mac_done`.
- R3: After `mac_done` the status word at offset 8 is written back with these fields:
  - the length in bits [15:0];
  - options bit 2 copied to bit 16;
  - bit 19 set when `mac_abort` was low;
  - bit 22 equal to `mac_abort`;
  - bit 23 equal to `mac_late`;
  - `mac_ccnt` in bits [31:28].
- R4: After the status write, the options word at offset 0 is written back with bit 31 cleared and bits [30:0] unchanged.
- R5: After the write-back, the current pointer takes the next pointer. While transmit-on is set, fetching continues there, so the ring wraps back through its next pointers.
- R6: A descriptor with options bit 31 at 0 stops the engine and sets status bit 23 (descriptor unavailable). No memory request follows until a start-demand write with transmit-on set. That write re-fetches the same descriptor.
- R7: Transmit-on is command bit 8. A start-demand write while it is clear does nothing. Clearing it during a frame lets that frame finish its write-back, and no further descriptor is fetched.
- R8: The status register bits are:
  - bit 16: frame interrupt, set on a finished frame whose options bit 2 is 1;
  - bit 18: complete, set on a frame finished without abort;
  - bit 22: abort;
  - bit 23: descriptor unavailable.

  `int_stat` shows bits [31:16]. Writing 1 to a bit clears it, and a new event wins over a clear in the same cycle.
- R9: `irq` is high exactly when some status bit and its enable bit (same position in the enable register) are both 1.
- R10: The memory port has one request outstanding at a time. Address, write enable and write data are held stable until `mem_ack`, and every address is word aligned.
- R11: No memory request is raised while `mac_req` is high.
- R12: The register selects are:
  - 0: start address;
  - 1: command;
  - 2: start demand (data ignored);
  - 3: status clear;
  - 4: interrupt enable.

  Reset clears all of them and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R12) |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| mac_req | output | 1 | Frame handed to MAC stub |
| mac_buf | output | ADDR_W | Frame buffer address |
| mac_len | output | 16 | Frame length in bytes |
| mac_pad | output | 1 | Pad short frames |
| mac_crc | output | 1 | Append CRC |
| mac_done | input | 1 | MAC stub finished the frame |
| mac_abort | input | 1 | Frame aborted |
| mac_late | input | 1 | Late collision seen |
| mac_ccnt | input | 4 | Collision count |
| int_stat | output | 16 | Interrupt status bits [31:16] |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the memory and MAC handshakes:
- requests held stable until acknowledged, and word aligned;
- memory and MAC traffic never overlapping;
- every options write-back dropping the owner bit;
- every status write-back carrying exactly one of complete or abort;
- `irq` never high with an empty status.

Only the directed scenarios can show the rest:
- the read order and offsets within a descriptor;
- the exact status and options words left in memory;
- the ring wrapping through its next pointer;
- the engine halting on a CPU-owned descriptor and resuming on start demand;
- the transmit-on gate, and the write-1-to-clear and enable masking of the status.

// File: rtl/txdr_pkg.sv
// Shared constants and types of the transmit descriptor ring engine.
// Assumes 32-bit memory words and the descriptor format of the brief.
package txdr_pkg;
    localparam int DW     = 32;  // memory word width
    localparam int LEN_W  = 16;  // frame length field
    localparam int CCNT_W = 4;   // collision count field
    localparam int SEL_W  = 3;   // register select width
    localparam int HALF   = DW / 2;

    // descriptor word offsets (bytes)
    localparam int OFS_OPT  = 0;
    localparam int OFS_BUF  = 4;
    localparam int OFS_STAT = 8;
    localparam int OFS_NEXT = 12;

    // options word bits
    localparam int OPT_PAD = 0;
    localparam int OPT_CRC = 1;
    localparam int OPT_IEN = 2;
    localparam int OPT_OWN = 31;

    // status word bits
    localparam int ST_IRQ  = 16;
    localparam int ST_DONE = 19;
    localparam int ST_ABT  = 22;
    localparam int ST_LATE = 23;

    // interrupt status register bits
    localparam int INT_FRAME = 16;
    localparam int INT_CMPL  = 18;
    localparam int INT_ABORT = 22;
    localparam int INT_UNAV  = 23;

    // command register bit
    localparam int CMD_TXON = 8;

    // register selects
    localparam logic [SEL_W-1:0] SEL_BASE  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CMD   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_KICK  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ISTAT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IEN   = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_OPT, S_RD_BUF, S_RD_STAT, S_RD_NEXT,
        S_XMIT, S_WR_STAT, S_WR_OPT, S_HALT
    } walk_t;

    // events passed from the walker to the register block
    typedef struct packed {
        logic frame_done;
        logic want_irq;
        logic aborted;
        logic unavail;
    } evt_t;
endpackage

// File: rtl/txdr_regs.sv
// Register block: start address, command, start demand, interrupt status
// (write-1-to-clear, upper half only) and interrupt enable.
// Assumes one register write per cycle; events from the walker win over clears.
module txdr_regs
    import txdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    input  evt_t              ev,
    output logic              base_load,
    output logic [ADDR_W-1:0] base_addr,
    output logic              tx_on,
    output logic              kick,
    output logic [HALF-1:0]   int_stat,
    output logic              irq
);
    logic [HALF-1:0] set_v, clr_v, en_q;
    logic            unused_bits;

    assign unused_bits = ^reg_wdata;
    assign base_load   = reg_wr && (reg_sel == SEL_BASE);
    assign base_addr   = {reg_wdata[ADDR_W-1:4], 4'b0000};
    assign kick        = reg_wr && (reg_sel == SEL_KICK);
    assign clr_v       = (reg_wr && reg_sel == SEL_ISTAT) ? reg_wdata[DW-1:HALF] : '0;

    // map walker events onto status bit positions
    always_comb begin
        set_v = '0;
        set_v[INT_FRAME-HALF] = ev.frame_done && ev.want_irq;
        set_v[INT_CMPL-HALF]  = ev.frame_done && !ev.aborted;
        set_v[INT_ABORT-HALF] = ev.frame_done && ev.aborted;
        set_v[INT_UNAV-HALF]  = ev.unavail;
    end

    // command and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_on <= 1'b0;
            en_q  <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_CMD) tx_on <= reg_wdata[CMD_TXON];
            if (reg_sel == SEL_IEN) en_q  <= reg_wdata[DW-1:HALF];
        end
    end

    // one write-1-to-clear status flop per bit, set wins
    for (genvar b = 0; b < HALF; b++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)          int_stat[b] <= 1'b0;
            else if (set_v[b])   int_stat[b] <= 1'b1;
            else if (clr_v[b])   int_stat[b] <= 1'b0;
        end
    end

    assign irq = |(int_stat & en_q);
endmodule

// File: rtl/txdr_walker.sv
// Descriptor walker: fetches the current descriptor, hands MAC-owned frames
// to the MAC stub, writes back status and options, follows the next pointer.
// Assumes the memory acks each request once; one request outstanding.
module txdr_walker
    import txdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              tx_on,
    input  logic              kick,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mac_req,
    output logic [ADDR_W-1:0] mac_buf,
    output logic [LEN_W-1:0]  mac_len,
    output logic              mac_pad,
    output logic              mac_crc,
    input  logic              mac_done,
    input  logic              mac_abort,
    input  logic              mac_late,
    input  logic [CCNT_W-1:0] mac_ccnt,
    output evt_t              ev
);
    walk_t              state;
    logic [ADDR_W-1:0]  cur, nxt_q, buf_q;
    logic [DW-2:0]      opt_q;
    logic [LEN_W-1:0]   len_q;
    logic               abort_q, late_q;
    logic [CCNT_W-1:0]  ccnt_q;
    logic [DW-1:0]      wb_stat;

    // status word as written back after the frame
    always_comb begin
        wb_stat = '0;
        wb_stat[LEN_W-1:0]     = len_q;
        wb_stat[ST_IRQ]        = opt_q[OPT_IEN];
        wb_stat[ST_DONE]       = !abort_q;
        wb_stat[ST_ABT]        = abort_q;
        wb_stat[ST_LATE]       = late_q;
        wb_stat[DW-1 -: CCNT_W] = ccnt_q;
    end

    // memory port driven from the state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        unique case (state)
            S_RD_OPT:  mem_addr = cur | ADDR_W'(OFS_OPT);
            S_RD_BUF:  mem_addr = cur | ADDR_W'(OFS_BUF);
            S_RD_STAT: mem_addr = cur | ADDR_W'(OFS_STAT);
            S_RD_NEXT: mem_addr = cur | ADDR_W'(OFS_NEXT);
            S_WR_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = cur | ADDR_W'(OFS_STAT);
                mem_wdata = wb_stat;
            end
            S_WR_OPT: begin
                mem_we    = 1'b1;
                mem_addr  = cur | ADDR_W'(OFS_OPT);
                mem_wdata = {1'b0, opt_q};
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign mac_req = (state == S_XMIT);
    assign mac_buf = buf_q;
    assign mac_len = len_q;
    assign mac_pad = opt_q[OPT_PAD];
    assign mac_crc = opt_q[OPT_CRC];

    // events towards the status register
    assign ev.frame_done = (state == S_WR_OPT) && mem_ack;
    assign ev.want_irq   = opt_q[OPT_IEN];
    assign ev.aborted    = abort_q;
    assign ev.unavail    = (state == S_RD_OPT) && mem_ack && !mem_rdata[OPT_OWN];

    // walker sequence and descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur     <= '0;
            nxt_q   <= '0;
            buf_q   <= '0;
            opt_q   <= '0;
            len_q   <= '0;
            abort_q <= 1'b0;
            late_q  <= 1'b0;
            ccnt_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (kick && tx_on) state <= S_RD_OPT;
                S_RD_OPT: if (mem_ack) begin
                    opt_q <= mem_rdata[DW-2:0];
                    state <= mem_rdata[OPT_OWN] ? S_RD_BUF : S_HALT;
                end
                S_RD_BUF: if (mem_ack) begin
                    buf_q <= mem_rdata[ADDR_W-1:0];
                    state <= S_RD_STAT;
                end
                S_RD_STAT: if (mem_ack) begin
                    len_q <= mem_rdata[LEN_W-1:0];
                    state <= S_RD_NEXT;
                end
                S_RD_NEXT: if (mem_ack) begin
                    nxt_q <= {mem_rdata[ADDR_W-1:4], 4'b0000};
                    state <= S_XMIT;
                end
                S_XMIT: if (mac_done) begin
                    abort_q <= mac_abort;
                    late_q  <= mac_late;
                    ccnt_q  <= mac_ccnt;
                    state   <= S_WR_STAT;
                end
                S_WR_STAT: if (mem_ack) state <= S_WR_OPT;
                S_WR_OPT: if (mem_ack) begin
                    cur   <= nxt_q;
                    state <= tx_on ? S_RD_OPT : S_IDLE;
                end
                S_HALT: begin
                    if (!tx_on)    state <= S_IDLE;
                    else if (kick) state <= S_RD_OPT;
                end
                default: state <= S_IDLE;
            endcase
            if (base_load) cur <= base_addr;
        end
    end
endmodule

// File: rtl/tx_desc_ring.sv
// Top of the transmit descriptor ring engine: register block plus walker.
// Assumes software loads the start address only while the engine is stopped.
module tx_desc_ring
    import txdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mac_req,
    output logic [ADDR_W-1:0] mac_buf,
    output logic [LEN_W-1:0]  mac_len,
    output logic              mac_pad,
    output logic              mac_crc,
    input  logic              mac_done,
    input  logic              mac_abort,
    input  logic              mac_late,
    input  logic [CCNT_W-1:0] mac_ccnt,
    output logic [HALF-1:0]   int_stat,
    output logic              irq
);
    evt_t              ev;
    logic              base_load, tx_on, kick;
    logic [ADDR_W-1:0] base_addr;

    txdr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ev(ev), .base_load(base_load),
        .base_addr(base_addr), .tx_on(tx_on), .kick(kick),
        .int_stat(int_stat), .irq(irq)
    );

    txdr_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_addr(base_addr),
        .tx_on(tx_on), .kick(kick), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mac_req(mac_req), .mac_buf(mac_buf),
        .mac_len(mac_len), .mac_pad(mac_pad), .mac_crc(mac_crc),
        .mac_done(mac_done), .mac_abort(mac_abort), .mac_late(mac_late),
        .mac_ccnt(mac_ccnt), .ev(ev)
    );
endmodule

// File: rtl/txdr_check.sv
// Protocol checker for tx_desc_ring, bound to every instance of the top.
module txdr_check
    import txdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_ack,
    input logic              mac_req,
    input logic              mac_done,
    input logic [ADDR_W-1:0] mac_buf,
    input logic [LEN_W-1:0]  mac_len,
    input logic [HALF-1:0]   int_stat,
    input logic              irq
);
    // R10: request held stable until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10: word-aligned addresses
    p_word_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R2: MAC handoff held until done
    p_mac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req && !mac_done |=> mac_req && $stable(mac_buf) && $stable(mac_len));

    // R11: no memory traffic during MAC handoff
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req |-> !mem_req);

    // R4: options write-back returns ownership to the CPU
    p_owner_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[3:0] == 4'h0 |-> !mem_wdata[OPT_OWN]);

    // R3: status write-back flags exactly one of complete and abort
    p_done_xor_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[3:0] == 4'h8 |-> mem_wdata[ST_DONE] != mem_wdata[ST_ABT]);

    // R9: interrupt only with a pending status bit
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_stat != '0);
endmodule

bind tx_desc_ring txdr_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mac_req(mac_req), .mac_done(mac_done), .mac_buf(mac_buf),
    .mac_len(mac_len), .int_stat(int_stat), .irq(irq)
);

// File: tb/tx_desc_ring_test.sv
// Directed bench for tx_desc_ring: memory model, MAC stub, one task per scenario.
module tx_desc_ring_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mac_req, mac_pad, mac_crc, mac_done;
    logic [31:0] mac_buf;
    logic [15:0] mac_len;
    logic        mac_abort = 1'b0, mac_late = 1'b0;
    logic [3:0]  mac_ccnt = '0;
    logic [15:0] int_stat;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    tx_desc_ring uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mac_req(mac_req), .mac_buf(mac_buf),
        .mac_len(mac_len), .mac_pad(mac_pad), .mac_crc(mac_crc),
        .mac_done(mac_done), .mac_abort(mac_abort), .mac_late(mac_late),
        .mac_ccnt(mac_ccnt), .int_stat(int_stat), .irq(irq)
    );

    // memory model with access log; bench pokes go through poke_*
    logic [31:0] mem [0:63];
    logic [31:0] log_addr [0:63];
    logic        log_we [0:63];
    int          log_n = 0;
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
                log_addr[log_n[5:0]] <= mem_addr;
                log_we[log_n[5:0]]   <= mem_we;
                log_n <= log_n + 1;
            end
            if (poke_en) mem[poke_idx] <= poke_val;
        end
    end

    // MAC stub: completes four cycles after a request, records the handoff
    int          mac_cnt = 0, n_frames = 0;
    logic [31:0] h_buf = '0;
    logic [15:0] h_len = '0;
    logic        h_pad = 1'b0, h_crc = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mac_done <= 1'b0;
            mac_cnt  <= 0;
        end else begin
            mac_done <= 1'b0;
            if (mac_req && !mac_done) begin
                if (mac_cnt == 3) begin
                    mac_done <= 1'b1;
                    mac_cnt  <= 0;
                    h_buf <= mac_buf; h_len <= mac_len;
                    h_pad <= mac_pad; h_crc <= mac_crc;
                    n_frames <= n_frames + 1;
                end else mac_cnt <= mac_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = idx[5:0]; poke_val = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_desc(input int w, input logic [31:0] opt, input logic [31:0] bufp,
                            input logic [31:0] len, input logic [31:0] nxt);
        poke(w, opt); poke(w + 1, bufp); poke(w + 2, len); poke(w + 3, nxt);
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_unav();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (int_stat[7]) break;
        end
    endtask

    task automatic t_reset();
        chk("R12 reset mem_req", {31'b0, mem_req}, 32'h0);
        chk("R12 reset mac_req", {31'b0, mac_req}, 32'h0);
        chk("R12 reset int_stat", {16'b0, int_stat}, 32'h0);
        chk("R12 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_single();
        int mark;
        put_desc(0, 32'h8000_0007, 32'h0000_1230, 32'h0000_0040, 32'h0000_0010);
        put_desc(4, 32'h0000_0003, 32'h0000_2000, 32'h0000_003C, 32'h0000_0000);
        wreg(3'd4, 32'hFFFF_0000);
        wreg(3'd0, 32'h0000_0005);
        wreg(3'd1, 32'h0000_0100);
        mark = log_n;
        wreg(3'd2, 32'h0000_ABCD);
        wait_unav();
        chk("R2 buf", h_buf, 32'h0000_1230);
        chk("R2 len", {16'b0, h_len}, 32'h40);
        chk("R2 pad", {31'b0, h_pad}, 32'h1);
        chk("R2 crc", {31'b0, h_crc}, 32'h1);
        chk("R1 fetch 0", log_addr[mark],     32'h00);
        chk("R1 fetch 1", log_addr[mark + 1], 32'h04);
        chk("R1 fetch 2", log_addr[mark + 2], 32'h08);
        chk("R1 fetch 3", log_addr[mark + 3], 32'h0C);
        chk("R3 status write addr", {log_addr[mark + 4][30:0], log_we[mark + 4]}, {31'h08, 1'b1});
        chk("R4 options write addr", {log_addr[mark + 5][30:0], log_we[mark + 5]}, {31'h00, 1'b1});
        chk("R5 next fetch", {log_addr[mark + 6][30:0], log_we[mark + 6]}, {31'h10, 1'b0});
        chk("R3 status word", mem[2], 32'h0009_0040);
        chk("R4 options word", mem[0], 32'h0000_0007);
        chk("R8 status bits", {16'b0, int_stat}, 32'h0085);
        chk("R9 irq", {31'b0, irq}, 32'h1);
        mark = log_n;
        repeat (20) @(negedge clk);
        chk("R6 halted no request", log_n, mark);
    endtask

    task automatic t_resume();
        wreg(3'd3, 32'hFFFF_0000);
        chk("R8 clear all", {16'b0, int_stat}, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        poke(4, 32'h8000_0003);
        wreg(3'd2, 32'h0);
        wait_unav();
        chk("R6 resume buf", h_buf, 32'h0000_2000);
        chk("R6 resume len", {16'b0, h_len}, 32'h3C);
        chk("R3 status no ien", mem[6], 32'h0008_003C);
        chk("R4 options D1", mem[4], 32'h0000_0003);
        chk("R8 no frame bit", {16'b0, int_stat}, 32'h0084);
        chk("R5 wrap to start", log_addr[log_n - 1], 32'h00);
    endtask

    task automatic t_abort();
        wreg(3'd3, 32'hFFFF_0000);
        mac_abort = 1'b1; mac_late = 1'b1; mac_ccnt = 4'd5;
        put_desc(0, 32'h8000_0004, 32'h0000_3000, 32'h0000_0100, 32'h0000_0010);
        wreg(3'd2, 32'h1);
        wait_unav();
        chk("R2 pad off", {31'b0, h_pad}, 32'h0);
        chk("R2 crc off", {31'b0, h_crc}, 32'h0);
        chk("R3 abort status", mem[2], 32'h50C1_0100);
        chk("R8 abort bits", {16'b0, int_stat}, 32'h00C1);
        mac_abort = 1'b0; mac_late = 1'b0; mac_ccnt = '0;
    endtask

    task automatic t_gate();
        int mark, frames;
        wreg(3'd3, 32'hFFFF_0000);
        wreg(3'd1, 32'h0);
        put_desc(0, 32'h8000_0003, 32'h0000_4000, 32'h0000_0050, 32'h0000_0010);
        put_desc(4, 32'h8000_0003, 32'h0000_5000, 32'h0000_0060, 32'h0000_0000);
        wreg(3'd0, 32'h0);
        mark = log_n;
        wreg(3'd2, 32'h0);
        repeat (20) @(negedge clk);
        chk("R7 kick ignored", log_n, mark);
        frames = n_frames;
        wreg(3'd1, 32'h100);
        wreg(3'd2, 32'h0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mac_req) break;
        end
        wreg(3'd1, 32'h0);
        repeat (40) @(negedge clk);
        chk("R7 one frame", n_frames, frames + 1);
        chk("R7 frame released", mem[0], 32'h0000_0003);
        chk("R7 next untouched", mem[4], 32'h8000_0003);
        chk("R7 no further fetch", log_n, mark + 6);
        chk("R7 status bits", {16'b0, int_stat}, 32'h0004);
    endtask

    task automatic t_mask();
        wreg(3'd4, 32'h0004_0000);
        chk("R9 enabled bit", {31'b0, irq}, 32'h1);
        wreg(3'd4, 32'h0080_0000);
        chk("R9 masked bit", {31'b0, irq}, 32'h0);
        wreg(3'd3, 32'h0080_0000);
        chk("R8 clear other bit", {16'b0, int_stat}, 32'h0004);
        wreg(3'd3, 32'h0004_0000);
        chk("R8 clear one bit", {16'b0, int_stat}, 32'h0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_resume();
        t_abort();
        t_gate();
        t_mask();
        report();
        $finish;
    end
endmodule